// File: doc/BRIEF.md
# Sparse-Carry Diminished-1 Modulo 2^n+1 Adder

This block adds two residues modulo 2^n+1. Both operands and the result use the diminished-1 encoding: an n-bit field holds the true value minus one, and a separate flag marks the value zero. The zero value is kept apart because the true range 0..2^n needs n+1 bits. The adder is meant for residue-number datapaths and for butterfly or transform arithmetic that works modulo a Fermat-style modulus.

In diminished-1 form the sum is the n-bit sum of the two stored fields, plus the inverted carry out of that sum, taken modulo 2^n. The inverted carry is not added in a second pass. It enters the carry network as a carry-in, so the carry network is fed back on itself. Carries come from a parallel-prefix structure that is deliberately sparse:

- Each group of K bits first forms its own group generate and propagate in log2 K small prefix levels.
- A Kogge-Stone tree over the N/K group signals then completes the sparse part in log2(N/K) further levels, which makes log2 N sparse levels in all.
- One final level folds the inverted end-around carry into every group boundary and fills in every carry inside each group.

An optional output register gives one cycle of latency, with a synchronous active-high reset.

Top module: `dim1_modadd`

## Requirements
- R1: With both zero flags low and a_val + b_val (taken as an (N+1)-bit sum) below 2^N-1, the result is s_val = a_val + b_val + 1 with s_zero = 0.
- R2: With both zero flags low and a_val + b_val at or above 2^N, the result is s_val = a_val + b_val - 2^N with s_zero = 0.
- R3: With both zero flags low and a_val + b_val exactly 2^N-1, the true sum is congruent to 0, so the result is s_zero = 1 and s_val = 0.
- R4: With a_zero = 1 and b_zero = 0, the result is s_val = b_val and s_zero = 0, whatever a_val holds.
- R5: With b_zero = 1 and a_zero = 0, the result is s_val = a_val and s_zero = 0, whatever b_val holds.
- R6: With both zero flags high, the result is s_zero = 1 and s_val = 0, whatever the value fields hold.
- R7: Whenever s_zero is 1, s_val is all zeros.
- R8: With REG_OUT = 1 (the default), the result appears one clock after the operands are sampled. While rst is high at a rising edge, the outputs are cleared to s_val = 0 and s_zero = 0.
- R9: The same function holds for any power-of-two N and any group size K of 2 or 4 that divides N. This includes N = 8 with K = 4, where the number of groups is two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_val | input | N | Operand A, stored as the true value minus one |
| a_zero | input | 1 | Operand A is zero (a_val is then ignored) |
| b_val | input | N | Operand B, stored as the true value minus one |
| b_zero | input | 1 | Operand B is zero (b_val is then ignored) |
| s_val | output | N | Result, stored as the true value minus one |
| s_zero | output | 1 | Result is zero |

## Verification
An exhaustive sweep of all operand pairs at N = 8 with K = 4 reaches every carry pattern between the two groups. It therefore separates errors in the group-boundary carries from errors in the filled-in carries inside a group. At N = 16 with K = 2, a table of chosen operands covers:
- sums just below, exactly at, and just above 2^N-1, which tell the no-wrap, zero-result and wrap cases apart;
- the pair of all-ones operands, which is the largest wrap;
- flag combinations carrying junk in the ignored field, which show that the bypass paths do not read that field.

Random operands with occasional zero flags then cover mixed propagate runs across many groups. Directed steps confirm the reset clearing and the one-cycle latency.

// File: rtl/dim1_pkg.sv
package dim1_pkg;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'b00,
        OPC_USE_A = 2'b01,
        OPC_USE_B = 2'b10,
        OPC_NONE  = 2'b11
    } opcase_e;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Combine a more significant span with the less significant span below it
    function automatic gp_t gp_merge(gp_t hi, gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // Select the result path from the two zero flags
    function automatic opcase_e pick_case(logic az, logic bz);
        opcase_e c;
        case ({az, bz})
            2'b00:   c = OPC_ADD;
            2'b01:   c = OPC_USE_A;
            2'b10:   c = OPC_USE_B;
            default: c = OPC_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dim1_blk_prefix.sv
module dim1_blk_prefix #(
    parameter int K = 2
) (
    input  logic [K-1:0] g_in,
    input  logic [K-1:0] p_in,
    output logic [K-1:0] loc_g,
    output logic [K-1:0] loc_p
);
    localparam int LK = $clog2(K);

    logic [K-1:0] lg [LK+1];
    logic [K-1:0] lp [LK+1];

    assign lg[0] = g_in;
    assign lp[0] = p_in;

    // Sklansky prefix inside one group: node o ends up spanning [o:0]
    for (genvar l = 1; l <= LK; l++) begin : g_lvl
        localparam int H = 1 << (l - 1);
        for (genvar o = 0; o < K; o++) begin : g_node
            if (((o >> (l - 1)) & 1) == 1) begin : g_mrg
                localparam int SRC = ((o >> l) << l) + H - 1;
                assign lg[l][o] = lg[l-1][o] | (lp[l-1][o] & lg[l-1][SRC]);
                assign lp[l][o] = lp[l-1][o] & lp[l-1][SRC];
            end else begin : g_pass
                assign lg[l][o] = lg[l-1][o];
                assign lp[l][o] = lp[l-1][o];
            end
        end
    end

    assign loc_g = lg[LK];
    assign loc_p = lp[LK];
endmodule

// File: rtl/dim1_sparse_tree.sv
module dim1_sparse_tree
    import dim1_pkg::*;
#(
    parameter int NB = 8
) (
    input  logic [NB-1:0] blk_g,
    input  logic [NB-1:0] blk_p,
    output logic [NB-1:0] pre_g,
    output logic [NB-1:0] pre_p
);
    localparam int LB = $clog2(NB);

    gp_t tn [LB+1][NB];

    for (genvar j = 0; j < NB; j++) begin : g_in
        assign tn[0][j] = '{g: blk_g[j], p: blk_p[j]};
    end

    // Kogge-Stone over group signals only: node j ends up spanning groups [j:0]
    for (genvar l = 1; l <= LB; l++) begin : g_lvl
        localparam int D = 1 << (l - 1);
        for (genvar j = 0; j < NB; j++) begin : g_node
            if (j >= D) begin : g_mrg
                assign tn[l][j] = gp_merge(tn[l-1][j], tn[l-1][j-D]);
            end else begin : g_pass
                assign tn[l][j] = tn[l-1][j];
            end
        end
    end

    for (genvar j = 0; j < NB; j++) begin : g_out
        assign pre_g[j] = tn[LB][j].g;
        assign pre_p[j] = tn[LB][j].p;
    end
endmodule

// File: rtl/dim1_carry_fill.sv
module dim1_carry_fill #(
    parameter int N = 16,
    parameter int K = 2
) (
    input  logic [N-1:0]          bit_p,
    input  logic [N/K*(K-1)-1:0]  inner_g,
    input  logic [N/K*(K-1)-1:0]  inner_p,
    input  logic [N/K-1:0]        pre_g,
    input  logic [N/K-1:0]        pre_p,
    output logic [N-1:0]          sum,
    output logic                  all_prop
);
    localparam int NB = N / K;
    localparam int KI = K - 1;

    logic          cin;
    logic [NB-1:0] cblk;
    logic [N-1:0]  cvec;

    // Inverted end-around carry: carry out of the whole word, negated
    assign cin     = ~pre_g[NB-1];
    assign cblk[0] = cin;

    for (genvar m = 1; m < NB; m++) begin : g_blk
        assign cblk[m] = pre_g[m-1] | (pre_p[m-1] & cin);
    end

    // Single extra level: every carry inside a group from its boundary carry
    for (genvar i = 0; i < N; i++) begin : g_bit
        localparam int M = i / K;
        localparam int O = i % K;
        if (O == 0) begin : g_first
            assign cvec[i] = cblk[M];
        end else begin : g_inner
            assign cvec[i] = inner_g[M*KI+O-1] | (inner_p[M*KI+O-1] & cblk[M]);
        end
    end

    assign sum      = bit_p ^ cvec;
    assign all_prop = pre_p[NB-1];
endmodule

// File: rtl/dim1_modadd.sv
module dim1_modadd
    import dim1_pkg::*;
#(
    parameter int N       = 16,
    parameter int K       = 2,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] a_val,
    input  logic         a_zero,
    input  logic [N-1:0] b_val,
    input  logic         b_zero,
    output logic [N-1:0] s_val,
    output logic         s_zero
);
    localparam int NB = N / K;
    localparam int KI = K - 1;

    typedef struct packed {
        logic         zero;
        logic [N-1:0] val;
    } res_t;

    if ((K != 2 && K != 4) || (N % K) != 0 || (N & (N - 1)) != 0) begin : g_bad
        $error("dim1_modadd: N must be a power of two and K (2 or 4) must divide it");
    end

    logic [N-1:0]     g_bit, p_bit;
    logic [N-1:0]     loc_g, loc_p;
    logic [NB-1:0]    blk_g, blk_p;
    logic [NB-1:0]    pre_g, pre_p;
    logic [NB*KI-1:0] inner_g, inner_p;
    logic [N-1:0]     sum;
    logic             all_prop;
    res_t             res_d;

    assign g_bit = a_val & b_val;
    assign p_bit = a_val ^ b_val;

    for (genvar m = 0; m < NB; m++) begin : g_grp
        dim1_blk_prefix #(.K(K)) u_blk (
            .g_in  (g_bit[m*K +: K]),
            .p_in  (p_bit[m*K +: K]),
            .loc_g (loc_g[m*K +: K]),
            .loc_p (loc_p[m*K +: K])
        );
        assign blk_g[m] = loc_g[m*K+K-1];
        assign blk_p[m] = loc_p[m*K+K-1];
        for (genvar o = 0; o < KI; o++) begin : g_inner
            assign inner_g[m*KI+o] = loc_g[m*K+o];
            assign inner_p[m*KI+o] = loc_p[m*K+o];
        end
    end

    dim1_sparse_tree #(.NB(NB)) u_tree (
        .blk_g (blk_g),
        .blk_p (blk_p),
        .pre_g (pre_g),
        .pre_p (pre_p)
    );

    dim1_carry_fill #(.N(N), .K(K)) u_fill (
        .bit_p    (p_bit),
        .inner_g  (inner_g),
        .inner_p  (inner_p),
        .pre_g    (pre_g),
        .pre_p    (pre_p),
        .sum      (sum),
        .all_prop (all_prop)
    );

    always_comb begin
        unique case (pick_case(a_zero, b_zero))
            OPC_ADD:   res_d = '{zero: all_prop, val: sum};
            OPC_USE_A: res_d = '{zero: 1'b0,     val: a_val};
            OPC_USE_B: res_d = '{zero: 1'b0,     val: b_val};
            default:   res_d = '{zero: 1'b1,     val: '0};
        endcase
    end

    if (REG_OUT) begin : g_reg
        res_t res_q;
        always_ff @(posedge clk) begin
            if (rst) res_q <= '0;
            else     res_q <= res_d;
        end
        assign s_val  = res_q.val;
        assign s_zero = res_q.zero;
    end else begin : g_comb
        assign s_val  = res_d.val;
        assign s_zero = res_d.zero;
    end
endmodule

// File: rtl/dim1_modadd_chk.sv
module dim1_modadd_chk #(
    parameter int N       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] a_val,
    input logic         a_zero,
    input logic [N-1:0] b_val,
    input logic         b_zero,
    input logic [N-1:0] s_val,
    input logic         s_zero
);
    logic [N:0]   raw_sum;
    logic [N-1:0] want_nowrap;
    logic [N-1:0] want_wrap;
    logic         both_live;

    assign raw_sum     = {1'b0, a_val} + {1'b0, b_val};
    assign want_nowrap = raw_sum[N-1:0] + 1'b1;
    assign want_wrap   = raw_sum[N-1:0];
    assign both_live   = !a_zero && !b_zero;

    always_comb begin
        if (!rst) begin
            AST_ZERO_CLEAN: assert (!(s_zero === 1'b1) || s_val == '0); // R7
        end
    end

    if (REG_OUT) begin : g_seq
        AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
            (both_live && raw_sum < (N+1)'((1 << N) - 1)) |=> (!s_zero && s_val == $past(want_nowrap))); // R1
        AST_WRAP: assert property (@(posedge clk) disable iff (rst)
            (both_live && raw_sum[N]) |=> (!s_zero && s_val == $past(want_wrap))); // R2
        AST_ZERO_SUM: assert property (@(posedge clk) disable iff (rst)
            (both_live && raw_sum == (N+1)'((1 << N) - 1)) |=> (s_zero && s_val == '0)); // R3
        AST_TAKE_B: assert property (@(posedge clk) disable iff (rst)
            (a_zero && !b_zero) |=> (!s_zero && s_val == $past(b_val))); // R4
        AST_TAKE_A: assert property (@(posedge clk) disable iff (rst)
            (!a_zero && b_zero) |=> (!s_zero && s_val == $past(a_val))); // R5
        AST_BOTH_ZERO: assert property (@(posedge clk) disable iff (rst)
            (a_zero && b_zero) |=> (s_zero && s_val == '0)); // R6
        AST_RST_CLEAR: assert property (@(posedge clk)
            rst |=> (!s_zero && s_val == '0)); // R8
    end
endmodule

bind dim1_modadd dim1_modadd_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .a_val  (a_val),
    .a_zero (a_zero),
    .b_val  (b_val),
    .b_zero (b_zero),
    .s_val  (s_val),
    .s_zero (s_zero)
);

// File: tb/dim1_modadd_bench.sv
module dim1_modadd_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a16 = '0, b16 = '0, s16;
    logic        az16 = 1'b0, bz16 = 1'b0, sz16;
    logic [7:0]  a8 = '0, b8 = '0, s8;
    logic        az8 = 1'b0, bz8 = 1'b0, sz8;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    dim1_modadd #(.N(16), .K(2), .REG_OUT(1'b1)) u_dim1_modadd (
        .clk(clk), .rst(rst), .a_val(a16), .a_zero(az16), .b_val(b16), .b_zero(bz16),
        .s_val(s16), .s_zero(sz16)
    );

    dim1_modadd #(.N(8), .K(4), .REG_OUT(1'b1)) u_dim1_modadd_n8 (
        .clk(clk), .rst(rst), .a_val(a8), .a_zero(az8), .b_val(b8), .b_zero(bz8),
        .s_val(s8), .s_zero(sz8)
    );

    // {a_zero, a_val, b_zero, b_val, exp_zero, exp_val}
    localparam logic [50:0] VEC [12] = '{
        {1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0001},   // R1 smallest
        {1'b0, 16'h1234, 1'b0, 16'h1111, 1'b0, 16'h2346},   // R1
        {1'b0, 16'hFFFF, 1'b0, 16'h0000, 1'b1, 16'h0000},   // R3
        {1'b0, 16'h8000, 1'b0, 16'h7FFF, 1'b1, 16'h0000},   // R3
        {1'b0, 16'hFFFF, 1'b0, 16'hFFFF, 1'b0, 16'hFFFE},   // R2 largest
        {1'b0, 16'hFFFF, 1'b0, 16'h0001, 1'b0, 16'h0000},   // R2
        {1'b0, 16'hFFFE, 1'b0, 16'h0000, 1'b0, 16'hFFFF},   // R1 top
        {1'b1, 16'hABCD, 1'b0, 16'h0042, 1'b0, 16'h0042},   // R4
        {1'b0, 16'h0042, 1'b1, 16'h5555, 1'b0, 16'h0042},   // R5
        {1'b1, 16'h0001, 1'b1, 16'h0002, 1'b1, 16'h0000},   // R6
        {1'b0, 16'h8000, 1'b0, 16'h8000, 1'b0, 16'h0000},   // R2
        {1'b0, 16'h8001, 1'b0, 16'h8000, 1'b0, 16'h0001}    // R2
    };

    // Behavioural model: true values, add, reduce mod 2^n+1, map back
    function automatic logic [16:0] ref_calc(int n, longint a, bit az, longint b, bit bz);
        longint m  = (longint'(1) << n) + 1;
        longint ta = az ? 0 : a + 1;
        longint tb = bz ? 0 : b + 1;
        longint s  = (ta + tb) % m;
        if (s == 0) return {1'b1, 16'h0000};
        return {1'b0, 16'(s - 1)};
    endfunction

    function automatic string req_of(int n, longint a, bit az, longint b, bit bz);
        longint top = (longint'(1) << n) - 1;
        if (az && bz) return "R6";
        if (az)       return "R4";
        if (bz)       return "R5";
        if (a + b == top) return "R3";
        if (a + b < top)  return "R1";
        return "R2";
    endfunction

    task automatic check(string tag, logic gz, logic [15:0] gv, logic ez, logic [15:0] ev);
        checks++;
        if (gz !== ez || gv !== ev) begin
            errors++;
            $display("FAIL %s: got zero=%0b val=%h expected zero=%0b val=%h", tag, gz, gv, ez, ev);
        end
        if (gz === 1'b1) begin
            checks++;
            if (gv !== 16'h0000) begin
                errors++;
                $display("FAIL R7: zero flag with val=%h expected val=0000", gv);
            end
        end
    endtask

    // Called at a negedge; drives, then samples at the following negedge
    task automatic run16(logic [15:0] a, logic az, logic [15:0] b, logic bz, logic ez, logic [15:0] ev, string tag);
        a16 = a; az16 = az; b16 = b; bz16 = bz;
        @(negedge clk);
        check(tag, sz16, s16, ez, ev);
    endtask

    task automatic run8(logic [7:0] a, logic az, logic [7:0] b, logic bz);
        logic [16:0] e;
        e  = ref_calc(8, a, az, b, bz);
        a8 = a; az8 = az; b8 = b; bz8 = bz;
        @(negedge clk);
        check({req_of(8, a, az, b, bz), " R9 N=8 K=4"}, sz8, {8'h00, s8}, e[16], e[15:0]);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run still busy after 150000 cycles, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [16:0] e;
        // R8: reset clears outputs even with live operands
        a16 = 16'h1234; b16 = 16'h4321; a8 = 8'h12; b8 = 8'h34;
        repeat (3) @(negedge clk);
        check("R8 reset n16", sz16, s16, 1'b0, 16'h0000);
        check("R8 reset n8", sz8, {8'h00, s8}, 1'b0, 16'h0000);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < 12; i++) begin
            run16(VEC[i][49:34], VEC[i][50], VEC[i][32:17], VEC[i][33], VEC[i][16], VEC[i][15:0],
                  {req_of(16, VEC[i][49:34], VEC[i][50], VEC[i][32:17], VEC[i][33]), " table"});
        end

        // R8 latency: output holds the old result until the next rising edge
        run16(16'h1234, 1'b0, 16'h1111, 1'b0, 1'b0, 16'h2346, "R1 latency setup");
        a16 = 16'h0000; b16 = 16'h0000;
        #2;
        check("R8 latency hold", sz16, s16, 1'b0, 16'h2346);
        @(negedge clk);
        check("R8 latency update", sz16, s16, 1'b0, 16'h0001);

        // R4 / R5 / R6 with junk in the ignored fields
        run16(16'hFFFF, 1'b1, 16'hFFFF, 1'b0, 1'b0, 16'hFFFF, "R4 junk a_val");
        run16(16'h0000, 1'b0, 16'hFFFF, 1'b1, 1'b0, 16'h0000, "R5 junk b_val");
        run16(16'hFFFF, 1'b1, 16'h0000, 1'b1, 1'b1, 16'h0000, "R6 junk both");

        // R9: exhaustive at N=8, K=4
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                run8(8'(a), 1'b0, 8'(b), 1'b0);
            end
        end
        for (int v = 0; v < 256; v++) begin
            run8(8'(v), 1'b1, 8'(255 - v), 1'b0);
            run8(8'(v), 1'b0, 8'(v * 7), 1'b1);
            run8(8'(v), 1'b1, 8'(v), 1'b1);
        end

        // Random at N=16
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ra, rb;
            logic        rza, rzb;
            ra  = 16'($urandom);
            rb  = 16'($urandom);
            rza = ($urandom % 8) == 0;
            rzb = ($urandom % 8) == 0;
            if (i % 10 == 0) rb = 16'hFFFF - ra;
            e = ref_calc(16, ra, rza, rb, rzb);
            run16(ra, rza, rb, rzb, e[16], e[15:0], {req_of(16, ra, rza, rb, rzb), " random"});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule